// File: doc/BRIEF.md
# Display Controller Run and Frame Buffer Register Bank

This block is the software-facing control bank of a parallel RGB display controller. A processor writes 32-bit words into a small register file. Each writable register can be written in three ways, chosen by address bits [3:2] inside the register's 16-byte slot:

- a plain write at the slot base;
- an OR write at base+4, which sets the bits written as 1;
- an AND-NOT write at base+8, which clears the bits written as 1.

From these registers the block drives the run, stream-mode, clock-gate, pixel-FIFO-flush and fetch-enable lines toward the fetch engine and the timing generator.

The frame buffer address is double-buffered. Software writes a pending address at any time. The block copies it into the scan-out address only when the timing generator pulses the start of a frame. Stopping is graceful: when software drops stream mode while running, the run flag stays high until the pixel FIFO reports empty. Only then does the run flag fall, and software can poll it. A soft-reset bit wipes the whole bank and holds run low for as long as it is set.

Top module: `dispctl_regbank`

## Requirements
- R1: After `rst_n` is released, every register reads 0, `run_o`, `fetch_en_o`, `stream_en_o`, `clk_gate_o` and `fifo_flush_o` are 0, and `cur_buf_o` is 0.
- R2: For each writable register, address bits [3:2] select the write kind: 00 stores the data, 01 ORs the data into the register, and 10 clears the bits that are 1 in the data. Slot 0x00 is control, 0x10 is auxiliary control, 0x20 is sync enable, and 0x40 is the pending buffer. The result is visible on a read at the slot base one cycle later.
- R3: A read at slot base+4 or base+8 returns the same value as a read at the slot base.
- R4: A write to the pending buffer (slot 0x40) leaves `cur_buf_o` unchanged. The cycle after `frame_start_i` is high, `cur_buf_o` and the read of slot 0x30 equal the pending value.
- R5: Slot 0x30 (scan-out address) is read-only: writes to it, through any alias, leave it unchanged.
- R6: While run (control bit 0) is 1 and stream mode (control bit 17) is 0, run stays 1 as long as `fifo_empty_i` is 0. Run reads 0 one cycle after a clock edge at which run is 1, stream mode is 0 and `fifo_empty_i` is 1.
- R7: Bit 21 of the auxiliary control register drives `fifo_flush_o`.
- R8: `fetch_en_o` is 1 only when run is 1 and sync-enable bit 0 (slot 0x20) is 1. Setting run with sync disabled gives no fetch enable.
- R9: Setting control bit 31 (soft reset) zeroes every other register, both buffer addresses included, in the same edge. While bit 31 stays set, run and every other bit hold at 0 even if written. Clearing bit 31 leaves the bank at 0.
- R10: Control bit 30 drives `clk_gate_o` and control bit 17 drives `stream_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | BUS_AW | Byte address; [BUS_AW-1:4] slot, [3:2] write kind |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data for `bus_addr_i` (combinational) |
| frame_start_i | input | 1 | One-cycle pulse at vertical sync from the timing generator |
| fifo_empty_i | input | 1 | Pixel FIFO empty flag |
| run_o | output | 1 | Run flag |
| stream_en_o | output | 1 | Dot-clock stream mode enable |
| clk_gate_o | output | 1 | Pixel clock gate request |
| fifo_flush_o | output | 1 | Pixel FIFO flush |
| fetch_en_o | output | 1 | Pixel fetch enable |
| cur_buf_o | output | DW | Scan-out frame buffer address |

## Verification
The register merge is tried with a table of plain, OR and AND-NOT writes on three different registers. The vectors are chosen so that each step flips bits that the previous step left set, which separates a true OR or AND-NOT from a plain overwrite. The buffer swap is tried with frame-start pulses both absent and present after a pending write, which tells a shadowed address from a direct one. The stop sequence holds the FIFO non-empty for several cycles before releasing it, which tells a drained stop from an immediate one. Soft reset is tried with writes that try to set run while it is held.

// File: rtl/dispctl_regbank.sv
module dispctl_regbank #(
  parameter int BUS_AW = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic              frame_start_i,
  input  logic              fifo_empty_i,
  output logic              run_o,
  output logic              stream_en_o,
  output logic              clk_gate_o,
  output logic              fifo_flush_o,
  output logic              fetch_en_o,
  output logic [DW-1:0]     cur_buf_o
);
  localparam int IW = BUS_AW - 4;
  localparam logic [IW-1:0] S_CTRL = IW'(0);
  localparam logic [IW-1:0] S_AUX  = IW'(1);
  localparam logic [IW-1:0] S_SYNC = IW'(2);
  localparam logic [IW-1:0] S_CUR  = IW'(3);
  localparam logic [IW-1:0] S_NEXT = IW'(4);
  localparam int B_RUN = 0, B_STREAM = 17, B_GATE = 30, B_SRST = 31, B_FLUSH = 21;

  logic [DW-1:0] ctrl_q, aux_q, sync_q, cur_q, next_q;
  logic [DW-1:0] ctrl_w, ctrl_nx;
  logic          srst_nx;

  wire [IW-1:0] slot = bus_addr_i[BUS_AW-1:4];
  wire [1:0]    kind = bus_addr_i[3:2];

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] wd,
                                          input logic [1:0] k);
    case (k)
      2'b00:   return wd;
      2'b01:   return old | wd;
      2'b10:   return old & ~wd;
      default: return old;
    endcase
  endfunction

  wire wr_ctrl = bus_wr_i && slot == S_CTRL;
  wire wr_aux  = bus_wr_i && slot == S_AUX;
  wire wr_sync = bus_wr_i && slot == S_SYNC;
  wire wr_next = bus_wr_i && slot == S_NEXT;
  wire drained = ctrl_q[B_RUN] && !ctrl_q[B_STREAM] && fifo_empty_i;

  always_comb begin
    ctrl_w = wr_ctrl ? merge(ctrl_q, bus_wdata_i, kind) : ctrl_q;
    if (drained) ctrl_w[B_RUN] = 1'b0;
    srst_nx = ctrl_w[B_SRST];
    ctrl_nx = srst_nx ? (DW'(1) << B_SRST) : ctrl_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      aux_q  <= '0;
      sync_q <= '0;
      cur_q  <= '0;
      next_q <= '0;
    end else begin
      ctrl_q <= ctrl_nx;
      if (srst_nx) begin
        aux_q  <= '0;
        sync_q <= '0;
        cur_q  <= '0;
        next_q <= '0;
      end else begin
        if (wr_aux)  aux_q  <= merge(aux_q, bus_wdata_i, kind);
        if (wr_sync) sync_q <= merge(sync_q, bus_wdata_i, kind);
        if (wr_next) next_q <= merge(next_q, bus_wdata_i, kind);
        if (frame_start_i) cur_q <= next_q;
      end
    end
  end

  always_comb begin
    case (slot)
      S_CTRL:  bus_rdata_o = ctrl_q;
      S_AUX:   bus_rdata_o = aux_q;
      S_SYNC:  bus_rdata_o = sync_q;
      S_CUR:   bus_rdata_o = cur_q;
      S_NEXT:  bus_rdata_o = next_q;
      default: bus_rdata_o = '0;
    endcase
  end

  assign run_o        = ctrl_q[B_RUN];
  assign stream_en_o  = ctrl_q[B_STREAM];
  assign clk_gate_o   = ctrl_q[B_GATE];
  assign fifo_flush_o = aux_q[B_FLUSH];
  assign fetch_en_o   = ctrl_q[B_RUN] && sync_q[0];
  assign cur_buf_o    = cur_q;
endmodule

// File: rtl/dispctl_regbank_chk.sv
module dispctl_regbank_chk #(
  parameter int BUS_AW = 8,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_i,
  input logic [BUS_AW-1:0] bus_addr_i,
  input logic              frame_start_i,
  input logic              fifo_empty_i,
  input logic              run_o,
  input logic              stream_en_o,
  input logic              fetch_en_o,
  input logic [DW-1:0]     cur_buf_o,
  input logic [DW-1:0]     ctrl_q,
  input logic [DW-1:0]     sync_q,
  input logic [DW-1:0]     next_q
);
  wire ctrl_wr = bus_wr_i && bus_addr_i[BUS_AW-1:4] == '0;

  a_r9_srst_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[31] |-> (!run_o && cur_buf_o == '0 && next_q == '0));

  a_r4_cur_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_i |=> ($stable(cur_buf_o) || ctrl_q[31]));

  a_r4_swap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (cur_buf_o == $past(next_q) || ctrl_q[31]));

  a_r8_fetch_gated: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en_o |-> (run_o && sync_q[0]));

  a_r6_hold_run: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !stream_en_o && !fifo_empty_i && !ctrl_wr) |=> run_o);

  a_r6_drain_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !stream_en_o && fifo_empty_i && !ctrl_wr) |=> !run_o);
endmodule

bind dispctl_regbank dispctl_regbank_chk #(.BUS_AW(BUS_AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .frame_start_i(frame_start_i), .fifo_empty_i(fifo_empty_i), .run_o(run_o),
  .stream_en_o(stream_en_o), .fetch_en_o(fetch_en_o), .cur_buf_o(cur_buf_o),
  .ctrl_q(ctrl_q), .sync_q(sync_q), .next_q(next_q)
);

// File: tb/dispctl_regbank_tb.sv
module dispctl_regbank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  localparam logic [71:0] VEC [NV] = '{
    {8'h20, 32'h0000_00F0, 32'h0000_00F0},
    {8'h24, 32'h0000_0003, 32'h0000_00F3},
    {8'h28, 32'h0000_0030, 32'h0000_00C3},
    {8'h10, 32'h0020_0000, 32'h0020_0000},
    {8'h18, 32'h0020_0000, 32'h0000_0000},
    {8'h14, 32'h0000_A005, 32'h0000_A005},
    {8'h40, 32'h1234_5678, 32'h1234_5678},
    {8'h48, 32'h0000_0078, 32'h1234_5600},
    {8'h44, 32'h0000_000F, 32'h1234_560F}
  };

  logic clk = 0, rst_n = 0, bus_wr = 0, frame_start = 0, fifo_empty = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, cur_buf;
  logic run, stream_en, clk_gate, fifo_flush, fetch_en;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dispctl_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .frame_start_i(frame_start),
    .fifo_empty_i(fifo_empty), .run_o(run), .stream_en_o(stream_en),
    .clk_gate_o(clk_gate), .fifo_flush_o(fifo_flush), .fetch_en_o(fetch_en),
    .cur_buf_o(cur_buf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  logic [31:0] v, v2;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int s = 0; s < 5; s++) begin
      rd(8'(s * 16), v);
      chk("R1 reg", v, 0);
    end
    chk("R1 outs", {27'd0, run, fetch_en, stream_en, clk_gate, fifo_flush}, 0);
    chk("R1 cur", cur_buf, 0);

    // R2 table of writes
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64] & 8'hF0, v);
      chk("R2 merge", v, VEC[i][31:0]);
      if (VEC[i][71:68] == 4'h1) chk("R7 flush", {31'd0, fifo_flush}, {31'd0, VEC[i][21]});
    end

    // R3 aliases read base
    rd(8'h20, v);
    rd(8'h24, v2);
    chk("R3 set alias read", v2, v);
    rd(8'h48, v2);
    chk("R3 clr alias read", v2, 32'h1234_560F);

    // R4 shadowed buffer
    chk("R4 no swap yet", cur_buf, 0);
    pulse_frame();
    chk("R4 swapped", cur_buf, 32'h1234_560F);
    rd(8'h30, v);
    chk("R4 cur read", v, 32'h1234_560F);
    wr(8'h40, 32'hAAAA_0000);
    repeat (3) @(negedge clk);
    chk("R4 pending only", cur_buf, 32'h1234_560F);

    // R5 cur is read-only
    wr(8'h30, 32'hDEAD_BEEF);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h30, v);
    chk("R5 cur unchanged", v, 32'h1234_560F);

    // R8 fetch gated by sync enable
    wr(8'h20, 32'h0);
    wr(8'h04, 32'h0002_0001);
    chk("R8 run set", {31'd0, run}, 1);
    chk("R8 no fetch without sync", {31'd0, fetch_en}, 0);
    chk("R10 stream", {31'd0, stream_en}, 1);
    wr(8'h24, 32'h1);
    chk("R8 fetch with sync", {31'd0, fetch_en}, 1);

    // R10 clock gate
    wr(8'h04, 32'h4000_0000);
    chk("R10 gate", {31'd0, clk_gate}, 1);
    wr(8'h08, 32'h4000_0000);
    chk("R10 gate off", {31'd0, clk_gate}, 0);

    // R6 drained stop
    fifo_empty = 0;
    wr(8'h08, 32'h0002_0000);
    repeat (4) @(negedge clk);
    chk("R6 run held", {31'd0, run}, 1);
    rd(8'h00, v);
    chk("R6 run bit held", v & 32'h1, 1);
    fifo_empty = 1;
    #1 chk("R6 not yet", {31'd0, run}, 1);
    @(posedge clk); #1;
    chk("R6 fell", {31'd0, run}, 0);
    rd(8'h00, v);
    chk("R6 readback", v, 0);
    fifo_empty = 0;

    // R9 soft reset
    wr(8'h04, 32'h0002_0001);
    pulse_frame();
    chk("R9 pre cur", cur_buf, 32'hAAAA_0000);
    wr(8'h04, 32'h8000_0000);
    chk("R9 run low", {31'd0, run}, 0);
    chk("R9 cur zero", cur_buf, 0);
    wr(8'h04, 32'h0000_0001);
    chk("R9 run held low", {31'd0, run}, 0);
    rd(8'h00, v);
    chk("R9 ctrl", v, 32'h8000_0000);
    for (int s = 1; s < 5; s++) begin
      rd(8'(s * 16), v);
      chk("R9 reg zero", v, 0);
    end
    wr(8'h08, 32'h8000_0000);
    rd(8'h00, v);
    chk("R9 released", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule